// File: doc/BRIEF.md
# Digital Phase-Frequency Comparator with Lock Flag

This block is the digital core of a frequency synthesizer's phase detector. Two pulse streams come in: one from the divided reference and one from the divided oscillator. They are sampled on the system clock. A rising edge on the reference stream raises an "up" request and a rising edge on the oscillator stream raises a "down" request. When both requests are raised, they are held together for a short, fixed overlap so the pump never sees a dead zone. Then both drop in the same cycle. The pump is idle whenever neither request is raised.

A control pin swaps the meaning of up and down, so the block suits loops with an inverting or a non-inverting filter. The requests are also presented on two pins for an external pump. One is a push-pull level. The other is an open-drain style pin that pulls low or releases. A lock flag compares the width of every comparison with a programmable window. It goes high after a run of good comparisons and shows a short low pulse during each comparison. A power-down request is only honoured once the pump is idle. A monitor pin shows a selected internal stream.

The pulse inputs carry no data words and have no back-pressure. Every edge is taken in the cycle it is sampled, so the block has no valid/ready handshake, and all of its pins are plain control and status levels.

Top module: `phase_comparator`

## Requirements
- R1: After reset, `pump_up`, `pump_dn`, `ext_pp`, `lock_det`, `sleeping` and `mon_out` are 0, and `ext_od_n` is 1.
- R2: With `pol_norm` high, a 0-to-1 change of `ref_in` raises `pump_up` in the cycle after the clock edge that samples it, and a 0-to-1 change of `vco_in` raises `pump_dn` in the same way. An input held high does not raise a request again.
- R3: Once both requests are raised, both stay high for exactly RST_DLY+1 cycles and then fall together. An input edge sampled at the clock edge where they fall raises its request again at once.
- R4: With `pol_norm` low, the outputs swap: reference edges drive `pump_dn` and oscillator edges drive `pump_up`.
- R5: `ext_pp` equals `pump_up` in every cycle. `ext_od_n` is 0 (pull low) exactly when `pump_dn` is 1, and 1 (released) otherwise.
- R6: A comparison is good when the number of cycles in which exactly one request was raised is below `lock_win`. `lock_det` is high after LOCK_N consecutive good comparisons, low in every cycle where any request is raised, and a single bad comparison drops it until LOCK_N further good ones have passed.
- R7: With `run_req` low, `sleeping` rises in the cycle after the first clock edge at which both requests are down. While a request is pending, edges are still taken so that the comparison can complete.
- R8: While `run_req` is low and both requests are down, input edges are ignored and `pump_up`, `pump_dn` and `lock_det` stay 0. The lock history is cleared, so after `run_req` returns high (`sleeping` falls after the next edge), LOCK_N fresh good comparisons are needed before `lock_det` rises.
- R9: `mon_sel` selects the value of `mon_out`: 0 gives constant 0, 1 gives `ref_in` delayed by one cycle, 2 gives `vco_in` delayed by one cycle, and 3 gives `lock_det`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_in | input | 1 | Divided reference pulse stream |
| vco_in | input | 1 | Divided oscillator pulse stream |
| pol_norm | input | 1 | 1 = normal pump polarity, 0 = swapped |
| run_req | input | 1 | 1 = run, 0 = request power-down |
| lock_win | input | WIN_W | Lock window in clock cycles (good if mismatch is below this) |
| mon_sel | input | 2 | Monitor source select |
| pump_up | output | 1 | Pump up request |
| pump_dn | output | 1 | Pump down request |
| ext_pp | output | 1 | External pump push-pull drive, mirrors pump_up |
| ext_od_n | output | 1 | External pump open-drain pin, 0 = pull low |
| lock_det | output | 1 | Lock flag with low pulses during comparisons |
| mon_out | output | 1 | Monitor output |
| sleeping | output | 1 | Power-down in effect |

## Verification
Two functions can land in the same cycle. The first is a power-down request that arrives while one request is still pending, so the shutdown must wait for the matching edge and the overlap to finish. The bench drops `run_req` in the middle of a comparison and judges it by counting the cycles in which `sleeping` is high while a pump output is active, which must stay at zero. The second is a fresh edge that falls on the clear cycle of the previous comparison. It is provoked with a reference pulse one cycle wide, repeated, and the bench judges it by the request reappearing right after the clear. A behavioural model compares every output on every cycle.

// File: rtl/pc_pkg.sv
package pc_pkg;
  typedef enum logic [1:0] {
    MON_OFF  = 2'd0,
    MON_REF  = 2'd1,
    MON_VCO  = 2'd2,
    MON_LOCK = 2'd3
  } mon_sel_e;
endpackage

// File: rtl/pc_edge_sense.sv
module pc_edge_sense #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sig,
  output logic [N-1:0] rise,
  output logic [N-1:0] dly
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dly[g] <= 1'b0;
      else        dly[g] <= sig[g];
    end
    assign rise[g] = sig[g] & ~dly[g];
  end
endmodule

// File: rtl/pc_flag_pair.sv
module pc_flag_pair #(
  parameter int RST_DLY = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_rise,
  input  logic vco_rise,
  input  logic accept,
  output logic up_q,
  output logic dn_q,
  output logic clr
);
  localparam int DZ_W = $clog2(RST_DLY + 2);

  logic [DZ_W-1:0] dz_q;
  logic            both;

  assign both = up_q & dn_q;

  if (RST_DLY == 0) begin : g_nodly
    assign clr = both;
  end else begin : g_dly
    assign clr = both && (dz_q == DZ_W'(RST_DLY));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
      dz_q <= '0;
    end else begin
      up_q <= (up_q & ~clr) | (ref_rise & accept);
      dn_q <= (dn_q & ~clr) | (vco_rise & accept);
      dz_q <= (both && !clr) ? dz_q + 1'b1 : '0;
    end
  end
endmodule

// File: rtl/pc_lock_judge.sv
module pc_lock_judge #(
  parameter int WIN_W  = 4,
  parameter int LOCK_N = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_q,
  input  logic             dn_q,
  input  logic             clr,
  input  logic             wipe,
  input  logic [WIN_W-1:0] lock_win,
  output logic             locked
);
  localparam int GOOD_W = $clog2(LOCK_N + 1);

  logic [WIN_W-1:0]  err_q;
  logic [GOOD_W-1:0] good_q;
  logic              good_now;

  assign good_now = err_q < lock_win;
  assign locked   = good_q == GOOD_W'(LOCK_N);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= '0;
      good_q <= '0;
    end else if (wipe) begin
      err_q  <= '0;
      good_q <= '0;
    end else if (clr) begin
      err_q <= '0;
      if (!good_now)   good_q <= '0;
      else if (!locked) good_q <= good_q + 1'b1;
    end else if ((up_q ^ dn_q) && (err_q != {WIN_W{1'b1}})) begin
      err_q <= err_q + 1'b1;
    end
  end
endmodule

// File: rtl/phase_comparator.sv
module phase_comparator #(
  parameter int RST_DLY = 1,
  parameter int WIN_W   = 4,
  parameter int LOCK_N  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_in,
  input  logic             vco_in,
  input  logic             pol_norm,
  input  logic             run_req,
  input  logic [WIN_W-1:0] lock_win,
  input  logic [1:0]       mon_sel,
  output logic             pump_up,
  output logic             pump_dn,
  output logic             ext_pp,
  output logic             ext_od_n,
  output logic             lock_det,
  output logic             mon_out,
  output logic             sleeping
);
  import pc_pkg::*;

  logic [1:0] rise, dly;
  logic       up_q, dn_q, clr, locked, sleep_go;

  pc_edge_sense #(.N(2)) u_edge (
    .clk(clk), .rst_n(rst_n), .sig({vco_in, ref_in}), .rise(rise), .dly(dly)
  );

  assign sleep_go = ~run_req & ~up_q & ~dn_q;

  pc_flag_pair #(.RST_DLY(RST_DLY)) u_flags (
    .clk(clk), .rst_n(rst_n), .ref_rise(rise[0]), .vco_rise(rise[1]),
    .accept(~sleep_go), .up_q(up_q), .dn_q(dn_q), .clr(clr)
  );

  pc_lock_judge #(.WIN_W(WIN_W), .LOCK_N(LOCK_N)) u_lock (
    .clk(clk), .rst_n(rst_n), .up_q(up_q), .dn_q(dn_q), .clr(clr),
    .wipe(sleep_go), .lock_win(lock_win), .locked(locked)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sleeping <= 1'b0;
    else        sleeping <= sleep_go;
  end

  assign pump_up  = pol_norm ? up_q : dn_q;
  assign pump_dn  = pol_norm ? dn_q : up_q;
  assign ext_pp   = pump_up;
  assign ext_od_n = ~pump_dn;
  assign lock_det = locked & ~up_q & ~dn_q & ~sleeping;

  always_comb begin
    case (mon_sel_e'(mon_sel))
      MON_REF:  mon_out = dly[0];
      MON_VCO:  mon_out = dly[1];
      MON_LOCK: mon_out = lock_det;
      default:  mon_out = 1'b0;
    endcase
  end
endmodule

// File: rtl/pc_checker.sv
module pc_checker #(
  parameter int RST_DLY = 1
) (
  input logic clk,
  input logic rst_n,
  input logic ref_in,
  input logic vco_in,
  input logic [1:0] mon_sel,
  input logic pump_up,
  input logic pump_dn,
  input logic lock_det,
  input logic mon_out,
  input logic sleeping
);
  localparam int OC_W = $clog2(RST_DLY + 3);
  logic [OC_W-1:0] ovl_cnt;
  logic            armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovl_cnt <= '0;
      armed   <= 1'b0;
    end else begin
      armed <= 1'b1;
      if (pump_up && pump_dn) begin
        if (ovl_cnt != {OC_W{1'b1}}) ovl_cnt <= ovl_cnt + 1'b1;
      end else begin
        ovl_cnt <= '0;
      end
    end
  end

  a_r3_overlap_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (pump_up && pump_dn) |-> (ovl_cnt <= OC_W'(RST_DLY)));

  a_r6_lock_low_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    lock_det |-> (!pump_up && !pump_dn));

  a_r7_sleep_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleeping) |-> $past(!pump_up && !pump_dn));

  a_r8_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    sleeping |-> (!pump_up && !pump_dn && !lock_det));

  a_r9_mon_ref: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && mon_sel == 2'd1) |-> (mon_out == $past(ref_in)));

  a_r9_mon_vco: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && mon_sel == 2'd2) |-> (mon_out == $past(vco_in)));
endmodule

bind phase_comparator pc_checker #(.RST_DLY(RST_DLY)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .vco_in(vco_in),
  .mon_sel(mon_sel), .pump_up(pump_up), .pump_dn(pump_dn),
  .lock_det(lock_det), .mon_out(mon_out), .sleeping(sleeping)
);

// File: tb/phase_comparator_tb_top.sv
module phase_comparator_tb_top;
  localparam int RST_DLY = 1;
  localparam int WIN_W   = 4;
  localparam int LOCK_N  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_in = 1'b0, vco_in = 1'b0, pol_norm = 1'b1, run_req = 1'b1;
  logic [WIN_W-1:0] lock_win = 4'd3;
  logic [1:0] mon_sel = 2'd0;
  logic pump_up, pump_dn, ext_pp, ext_od_n, lock_det, mon_out, sleeping;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  phase_comparator #(.RST_DLY(RST_DLY), .WIN_W(WIN_W), .LOCK_N(LOCK_N)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .vco_in(vco_in),
    .pol_norm(pol_norm), .run_req(run_req), .lock_win(lock_win),
    .mon_sel(mon_sel), .pump_up(pump_up), .pump_dn(pump_dn), .ext_pp(ext_pp),
    .ext_od_n(ext_od_n), .lock_det(lock_det), .mon_out(mon_out),
    .sleeping(sleeping)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", what, act, exp, $time);
    end
  endtask

  // Behavioural reference model, stepped on every clock.
  int m_rd, m_vd, m_up, m_dn, m_dz, m_err, m_good, m_sleep;
  int e_pu, e_pd, e_ld, e_mon;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rd = 0; m_vd = 0; m_up = 0; m_dn = 0; m_dz = 0;
      m_err = 0; m_good = 0; m_sleep = 0;
    end else begin
      int rr, vr, bth, cl, go, nu, nd;
      rr  = (ref_in && !m_rd) ? 1 : 0;
      vr  = (vco_in && !m_vd) ? 1 : 0;
      bth = (m_up && m_dn) ? 1 : 0;
      cl  = (bth && m_dz == RST_DLY) ? 1 : 0;
      go  = (!run_req && !m_up && !m_dn) ? 1 : 0;
      nu  = ((cl ? 0 : m_up) || (rr && !go)) ? 1 : 0;
      nd  = ((cl ? 0 : m_dn) || (vr && !go)) ? 1 : 0;
      m_dz = (bth && !cl) ? m_dz + 1 : 0;
      if (go) begin
        m_err = 0; m_good = 0;
      end else if (cl) begin
        if (m_err < int'(lock_win)) m_good = (m_good < LOCK_N) ? m_good + 1 : LOCK_N;
        else m_good = 0;
        m_err = 0;
      end else if ((m_up != m_dn) && m_err < (1 << WIN_W) - 1) begin
        m_err = m_err + 1;
      end
      m_up = nu; m_dn = nd; m_sleep = go;
      m_rd = ref_in; m_vd = vco_in;
    end
    #2;
    e_pu = pol_norm ? m_up : m_dn;
    e_pd = pol_norm ? m_dn : m_up;
    e_ld = (m_good == LOCK_N && !m_up && !m_dn && !m_sleep) ? 1 : 0;
    case (mon_sel)
      2'd1: e_mon = m_rd;
      2'd2: e_mon = m_vd;
      2'd3: e_mon = e_ld;
      default: e_mon = 0;
    endcase
    if (!done) begin
      chk(pump_up == e_pu[0], "R2 R4 pump_up", pump_up, e_pu);
      chk(pump_dn == e_pd[0], "R2 R4 pump_dn", pump_dn, e_pd);
      chk(ext_pp == e_pu[0], "R5 ext_pp", ext_pp, e_pu);
      chk(ext_od_n == !e_pd[0], "R5 ext_od_n", ext_od_n, !e_pd[0]);
      chk(lock_det == e_ld[0], "R6 lock_det", lock_det, e_ld);
      chk(sleeping == m_sleep[0], "R7 sleeping", sleeping, m_sleep);
      chk(mon_out == e_mon[0], "R9 mon_out", mon_out, e_mon);
    end
  end

  // Counters sampled mid-cycle (negedge) during each stimulus burst.
  int c_uo, c_do, c_both, c_ldlow, c_mon, c_sleepact, c_act;

  task automatic sample();
    if (pump_up && !pump_dn) c_uo++;
    if (pump_dn && !pump_up) c_do++;
    if (pump_up && pump_dn) c_both++;
    if (!lock_det) c_ldlow++;
    if (mon_out) c_mon++;
    if (sleeping && (pump_up || pump_dn)) c_sleepact++;
    if (pump_up || pump_dn) c_act++;
  endtask

  task automatic fire(input int ra, input int va, input int gap);
    c_uo = 0; c_do = 0; c_both = 0; c_ldlow = 0; c_mon = 0; c_sleepact = 0; c_act = 0;
    for (int i = 0; i < gap; i++) begin
      @(negedge clk);
      sample();
      ref_in = (ra >= 0 && i >= ra && i < ra + 2);
      vco_in = (va >= 0 && i >= va && i < va + 2);
    end
    @(negedge clk);
    sample();
    ref_in = 0; vco_in = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired act=0 exp=1");
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!pump_up && !pump_dn && !ext_pp && ext_od_n, "R1 pumps idle", pump_up | pump_dn, 0);
    chk(!lock_det && !sleeping && !mon_out, "R1 flags low", lock_det | sleeping | mon_out, 0);

    // R2 reference leads by 3: up alone 3 cycles, overlap RST_DLY+1
    fire(0, 3, 12);
    chk(c_uo == 3, "R2 up-only cycles", c_uo, 3);
    chk(c_do == 0, "R2 no down-only", c_do, 0);
    chk(c_both == RST_DLY + 1, "R3 overlap length", c_both, RST_DLY + 1);

    // R2 oscillator leads
    fire(4, 0, 12);
    chk(c_do == 4, "R2 down-only cycles", c_do, 4);

    // R2 held input does not retrigger: long reference level
    c_uo = 0;
    ref_in = 1;
    repeat (6) begin @(negedge clk); sample(); end
    vco_in = 1;
    repeat (6) begin @(negedge clk); sample(); end
    ref_in = 0; vco_in = 0;
    repeat (4) @(negedge clk);
    chk(!pump_up && !pump_dn, "R2 held level no retrigger", pump_up | pump_dn, 0);

    // R4 swapped polarity
    pol_norm = 0;
    fire(0, 3, 12);
    chk(c_do == 3 && c_uo == 0, "R4 swapped direction", c_do, 3);
    pol_norm = 1;

    // R6 lock after LOCK_N aligned comparisons, window 3
    lock_win = 4'd3;
    repeat (4) fire(0, 0, 10);
    chk(lock_det == 1, "R6 locked after run", lock_det, 1);
    mon_sel = 2'd3;
    fire(0, 0, 10);
    chk(c_ldlow == RST_DLY + 1, "R6 narrow low pulse", c_ldlow, RST_DLY + 1);
    chk(c_mon == 10 - RST_DLY, "R9 monitor lock", c_mon, 10 - RST_DLY);
    fire(0, 5, 12);
    chk(lock_det == 0, "R6 bad comparison drops lock", lock_det, 0);
    repeat (3) fire(0, 2, 12);
    chk(lock_det == 1, "R6 relock within window", lock_det, 1);

    // R3 edge on the clear cycle re-raises the request
    c_uo = 0;
    @(negedge clk); ref_in = 1; vco_in = 1;
    @(negedge clk); ref_in = 0; vco_in = 0;
    @(negedge clk); ref_in = 1;
    @(negedge clk); ref_in = 0;
    @(negedge clk);
    chk(pump_up && !pump_dn, "R3 edge in clear cycle", pump_up, 1);
    fire(-1, 0, 10);

    // R9 monitor streams
    mon_sel = 2'd1;
    fire(0, 4, 12);
    chk(c_mon == 2, "R9 monitor ref", c_mon, 2);
    mon_sel = 2'd2;
    fire(1, 5, 12);
    chk(c_mon == 2, "R9 monitor vco", c_mon, 2);
    mon_sel = 2'd0;
    fire(0, 3, 12);
    chk(c_mon == 0, "R9 monitor off", c_mon, 0);

    // R7 power-down requested mid-comparison
    c_sleepact = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      sample();
      ref_in = (i < 2);
      vco_in = (i >= 6 && i < 8);
      if (i == 2) run_req = 0;
    end
    @(negedge clk);
    chk(c_sleepact == 0, "R7 no sleep while pumping", c_sleepact, 0);
    chk(sleeping == 1, "R7 sleep after idle", sleeping, 1);

    // R8 edges ignored while asleep
    fire(0, 3, 10);
    chk(c_act == 0, "R8 edges ignored asleep", c_act, 0);
    chk(lock_det == 0, "R8 lock low asleep", lock_det, 0);
    run_req = 1;
    fire(0, 0, 10);
    chk(sleeping == 0, "R8 wake", sleeping, 0);
    chk(lock_det == 0, "R8 history cleared", lock_det, 0);
    repeat (2) fire(0, 1, 10);
    chk(lock_det == 1, "R8 relock after wake", lock_det, 1);

    // Phase sweep in both polarities
    for (int p = 0; p < 2; p++) begin
      pol_norm = p[0];
      for (int d = -4; d <= 6; d++) fire(d >= 0 ? 0 : -d, d >= 0 ? d : 0, 14);
    end

    repeat (4) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule